// File: doc/BRIEF.md
# Command Stream Header Decoder

This block sits in a command processor's front end. It watches a stream of 32-bit command words that move under a valid/ready handshake. It decides whether each word is a header or a payload word. Every header is broken into its fields: an opcode in the top four bits, then a register offset, class, mask, count or immediate data, depending on the opcode. Every word passes straight through with a tag. A header carries its decoded fields. A payload word carries the register offset it writes.

The payload length comes from the opcode. For a set-class header it is the number of set bits in a 6-bit mask. For a masked write it is the number of set bits in a 16-bit mask. Incrementing and non-incrementing writes give it as an explicit 16-bit count. A gather has exactly one address word. Immediate, restart and extended headers have no payload. Lock acquire and lock release requests in extended headers come out as single-cycle pulses with the lock index. Gather fetching, register execution and lock arbitration belong to other blocks.

Top module: `cmd_hdr_decoder`

## Requirements
- R1: After reset or after a payload run ends, the next word accepted is decoded as a header. `out_opcode` shows bits 31:28: 0 set-class, 1 incrementing write, 2 non-incrementing write, 3 masked write, 4 immediate, 5 restart, 6 gather, 14 extended. For opcodes 0 to 4 and 6, `out_offset` is bits 27:16.
- R2: An incrementing write (opcode 1) is followed by bits 15:0 payload words. The first payload word goes to the header offset, and each later one goes to the previous offset plus one, wrapping at 12 bits. A count of zero means the next word is a header.
- R3: A non-incrementing write (opcode 2) is followed by bits 15:0 payload words, and all of them go to the header offset.
- R4: A masked write (opcode 3) is followed by as many payload words as there are set bits in mask bits 15:0. Payload word k goes to the header offset plus the bit position of the k-th set mask bit, counted from bit 0 upward.
- R5: A set-class header (opcode 0) reports the class in bits 15:6 and the mask in bits 5:0. Its payload follows the R4 rule using the 6-bit mask. A zero mask gives no payload.
- R6: An immediate header (opcode 4) shows bits 15:0 on `out_imm`. A restart header (opcode 5) shows the header shifted left by 4 on `out_restart_addr`. Neither has payload.
- R7: A gather header (opcode 6) shows bit 15 as insert, bit 14 as type and bits 13:0 as a word count. Exactly one payload word follows it, tagged with the header offset.
- R8: An extended header (opcode 14) with sub-opcode bits 27:24 = 0 pulses `lock_acq` for one cycle. Sub-opcode 1 pulses `lock_rel`. In both cases `lock_idx` is bits 7:0. Any other sub-opcode pulses `out_ext_unknown`. None of them has payload.
- R9: Opcodes 7 to 13 and 15 pulse `out_bad_opcode`, carry no payload, and the next word is decoded as a header.
- R10: A synchronous `flush` clears the pending payload count, so the next word accepted is a header.
- R11: `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`. A word advances the decode state or raises an event pulse only in a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous return to header expectation |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when valid |
| in_data | input | 32 | Command word |
| out_valid | output | 1 | Tagged word valid |
| out_ready | input | 1 | Downstream can take the word |
| out_data | output | 32 | Word passed through |
| out_is_hdr | output | 1 | Word is a header |
| out_opcode | output | 4 | Header opcode; on payload, the opcode of its header |
| out_offset | output | 12 | Header offset, or the target offset of a payload word |
| out_class | output | 10 | Class of a set-class header |
| out_mask | output | 16 | Write mask (6 or 16 bits used) |
| out_count | output | 16 | Payload words that follow this header |
| out_imm | output | 16 | Immediate data |
| out_restart_addr | output | 32 | Restart target address |
| out_gather_insert | output | 1 | Gather insert flag |
| out_gather_type | output | 1 | Gather type flag |
| out_gather_words | output | 14 | Gather word count |
| lock_acq | output | 1 | Lock acquire pulse |
| lock_rel | output | 1 | Lock release pulse |
| lock_idx | output | 8 | Lock index |
| out_ext_unknown | output | 1 | Unknown extended sub-opcode pulse |
| out_bad_opcode | output | 1 | Unused opcode pulse |

## Verification
The hardest situation to reach from the ports is a word boundary that sits in the wrong place. That happens when a header has a zero-length payload (a count of zero, an empty set-class mask, or an unused opcode), or when a flush arrives partway through a payload run. If the boundary is misplaced, every later word is misread. The stimulus table places such headers directly ahead of further headers, so that every word that follows checks where the boundary fell. Directed sequences then add a flush in the middle of a burst, and a stalled downstream that presents a lock request and a payload word without accepting them.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;

    localparam int WORD_W = 32;
    localparam int OFS_W  = 12;
    localparam int CNT_W  = 16;
    localparam int CLS_W  = 10;
    localparam int MSK_W  = 16;
    localparam int LCK_W  = 8;
    localparam int MIDX_W = $clog2(MSK_W);

    localparam logic [3:0] OP_SETCLASS = 4'd0;
    localparam logic [3:0] OP_INCR     = 4'd1;
    localparam logic [3:0] OP_NONINCR  = 4'd2;
    localparam logic [3:0] OP_MASK     = 4'd3;
    localparam logic [3:0] OP_IMM      = 4'd4;
    localparam logic [3:0] OP_RESTART  = 4'd5;
    localparam logic [3:0] OP_GATHER   = 4'd6;
    localparam logic [3:0] OP_EXTEND   = 4'd14;

    typedef enum logic [1:0] {
        STEP_INC  = 2'd0,
        STEP_FIX  = 2'd1,
        STEP_MASK = 2'd2
    } step_e;

    typedef struct packed {
        logic [3:0]        opcode;
        logic [OFS_W-1:0]  offset;
        logic [CLS_W-1:0]  class_id;
        logic [MSK_W-1:0]  mask;
        logic [CNT_W-1:0]  count;
        step_e             step;
        logic [15:0]       imm;
        logic [WORD_W-1:0] restart_addr;
        logic              g_insert;
        logic              g_type;
        logic [13:0]       g_words;
        logic              lock_acq;
        logic              lock_rel;
        logic [LCK_W-1:0]  lock_idx;
        logic              ext_unknown;
        logic              bad_op;
    } hdr_t;

    function automatic logic [CNT_W-1:0] popcount(input logic [MSK_W-1:0] m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < MSK_W; i++) n = n + CNT_W'(m[i]);
        return n;
    endfunction

    function automatic logic [MIDX_W-1:0] lowest_set(input logic [MSK_W-1:0] m);
        logic [MIDX_W-1:0] p;
        p = '0;
        for (int i = MSK_W - 1; i >= 0; i--) if (m[i]) p = MIDX_W'(i);
        return p;
    endfunction

endpackage

// File: rtl/cmd_hdr_field_dec.sv
module cmd_hdr_field_dec
    import cmd_dec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hd
);
    logic [3:0] op;
    assign op = word[31:28];

    always_comb begin
        hd              = '0;
        hd.opcode       = op;
        hd.step         = STEP_FIX;
        hd.offset       = word[27:16];
        case (op)
            OP_SETCLASS: begin
                hd.class_id = word[15:6];
                hd.mask     = {{(MSK_W-6){1'b0}}, word[5:0]};
                hd.count    = popcount(hd.mask);
                hd.step     = STEP_MASK;
            end
            OP_INCR: begin
                hd.count = word[15:0];
                hd.step  = STEP_INC;
            end
            OP_NONINCR: hd.count = word[15:0];
            OP_MASK: begin
                hd.mask  = word[15:0];
                hd.count = popcount(word[15:0]);
                hd.step  = STEP_MASK;
            end
            OP_IMM: hd.imm = word[15:0];
            OP_RESTART: begin
                hd.offset       = '0;
                hd.restart_addr = {word[27:0], 4'b0000};
            end
            OP_GATHER: begin
                hd.g_insert = word[15];
                hd.g_type   = word[14];
                hd.g_words  = word[13:0];
                hd.count    = CNT_W'(1);
            end
            OP_EXTEND: begin
                hd.offset   = '0;
                hd.lock_idx = word[7:0];
                case (word[27:24])
                    4'd0:    hd.lock_acq    = 1'b1;
                    4'd1:    hd.lock_rel    = 1'b1;
                    default: hd.ext_unknown = 1'b1;
                endcase
            end
            default: begin
                hd.offset = '0;
                hd.bad_op = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cmd_payload_track.sv
module cmd_payload_track
    import cmd_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             hdr_fire,
    input  logic             pay_fire,
    input  logic [3:0]       hdr_opcode,
    input  logic [OFS_W-1:0] hdr_offset,
    input  logic [MSK_W-1:0] hdr_mask,
    input  logic [CNT_W-1:0] hdr_count,
    input  step_e            hdr_step,
    output logic             expect_hdr,
    output logic [OFS_W-1:0] pay_offset,
    output logic [3:0]       cur_opcode
);
    logic [CNT_W-1:0] remaining;
    logic [OFS_W-1:0] base;
    logic [OFS_W-1:0] step_idx;
    logic [MSK_W-1:0] mask_left;
    step_e            step;

    assign expect_hdr = (remaining == '0);

    always_comb begin
        case (step)
            STEP_INC:  pay_offset = base + step_idx;
            STEP_MASK: pay_offset = base + OFS_W'(lowest_set(mask_left));
            default:   pay_offset = base;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining  <= '0;
            base       <= '0;
            step_idx   <= '0;
            mask_left  <= '0;
            step       <= STEP_FIX;
            cur_opcode <= '0;
        end else if (flush) begin
            remaining <= '0;
        end else if (hdr_fire) begin
            remaining  <= hdr_count;
            base       <= hdr_offset;
            step_idx   <= '0;
            mask_left  <= hdr_mask;
            step       <= hdr_step;
            cur_opcode <= hdr_opcode;
        end else if (pay_fire) begin
            remaining <= remaining - CNT_W'(1);
            step_idx  <= step_idx + OFS_W'(1);
            mask_left <= mask_left & (mask_left - MSK_W'(1));
        end
    end
endmodule

// File: rtl/cmd_hdr_decoder.sv
module cmd_hdr_decoder
    import cmd_dec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_is_hdr,
    output logic [3:0]  out_opcode,
    output logic [11:0] out_offset,
    output logic [9:0]  out_class,
    output logic [15:0] out_mask,
    output logic [15:0] out_count,
    output logic [15:0] out_imm,
    output logic [31:0] out_restart_addr,
    output logic        out_gather_insert,
    output logic        out_gather_type,
    output logic [13:0] out_gather_words,
    output logic        lock_acq,
    output logic        lock_rel,
    output logic [7:0]  lock_idx,
    output logic        out_ext_unknown,
    output logic        out_bad_opcode
);
    hdr_t             hd;
    logic             expect_hdr;
    logic             fire;
    logic             hdr_fire;
    logic [OFS_W-1:0] pay_offset;
    logic [3:0]       cur_opcode;

    cmd_hdr_field_dec u_dec (
        .word (in_data),
        .hd   (hd)
    );

    assign fire     = in_valid && out_ready;
    assign hdr_fire = fire && expect_hdr;

    cmd_payload_track u_track (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .hdr_fire   (hdr_fire),
        .pay_fire   (fire && !expect_hdr),
        .hdr_opcode (hd.opcode),
        .hdr_offset (hd.offset),
        .hdr_mask   (hd.mask),
        .hdr_count  (hd.count),
        .hdr_step   (hd.step),
        .expect_hdr (expect_hdr),
        .pay_offset (pay_offset),
        .cur_opcode (cur_opcode)
    );

    assign in_ready          = out_ready;
    assign out_valid         = in_valid;
    assign out_data          = in_data;
    assign out_is_hdr        = expect_hdr;
    assign out_opcode        = expect_hdr ? hd.opcode : cur_opcode;
    assign out_offset        = expect_hdr ? hd.offset : pay_offset;
    assign out_class         = hd.class_id;
    assign out_mask          = hd.mask;
    assign out_count         = hd.count;
    assign out_imm           = hd.imm;
    assign out_restart_addr  = hd.restart_addr;
    assign out_gather_insert = hd.g_insert;
    assign out_gather_type   = hd.g_type;
    assign out_gather_words  = hd.g_words;
    assign lock_idx          = hd.lock_idx;
    assign lock_acq          = hdr_fire && hd.lock_acq;
    assign lock_rel          = hdr_fire && hd.lock_rel;
    assign out_ext_unknown   = hdr_fire && hd.ext_unknown;
    assign out_bad_opcode    = hdr_fire && hd.bad_op;
endmodule

// File: rtl/cmd_hdr_decoder_chk.sv
module cmd_hdr_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_is_hdr,
    input logic [3:0]  out_opcode,
    input logic [11:0] out_offset,
    input logic        lock_acq,
    input logic        lock_rel,
    input logic        out_ext_unknown,
    input logic        out_bad_opcode
);
    logic took_pay;
    assign took_pay = out_valid && out_ready && !out_is_hdr;

    a_r8_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lock_acq, lock_rel, out_ext_unknown, out_bad_opcode}));

    a_r8_pulse_on_header: assert property (@(posedge clk) disable iff (rst)
        (lock_acq || lock_rel) |-> (out_valid && out_is_hdr));

    a_r11_no_event_when_stalled: assert property (@(posedge clk) disable iff (rst)
        !out_ready |-> !(lock_acq || lock_rel || out_ext_unknown || out_bad_opcode));

    a_r10_flush_to_header: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!out_valid || out_is_hdr));

    a_r9_bad_no_payload: assert property (@(posedge clk) disable iff (rst)
        out_bad_opcode |=> (!out_valid || out_is_hdr));

    a_r6_no_payload_after_imm: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_is_hdr &&
         (out_opcode == 4'd4 || out_opcode == 4'd5)) |=> (!out_valid || out_is_hdr));

    a_r3_nonincr_fixed: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_hdr && out_opcode == 4'd2 &&
         $past(took_pay) && !$past(flush)) |-> (out_offset == $past(out_offset)));

    a_r2_incr_step: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_hdr && out_opcode == 4'd1 &&
         $past(took_pay) && !$past(flush)) |-> (out_offset == $past(out_offset) + 12'd1));
endmodule

bind cmd_hdr_decoder cmd_hdr_decoder_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .flush           (flush),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_is_hdr      (out_is_hdr),
    .out_opcode      (out_opcode),
    .out_offset      (out_offset),
    .lock_acq        (lock_acq),
    .lock_rel        (lock_rel),
    .out_ext_unknown (out_ext_unknown),
    .out_bad_opcode  (out_bad_opcode)
);

// File: tb/cmd_hdr_decoder_tb.sv
`timescale 1ns/1ps
module cmd_hdr_decoder_tb;
    logic        clk = 1'b0;
    logic        rst, flush, in_valid, in_ready, out_valid, out_ready, out_is_hdr;
    logic [31:0] in_data, out_data, out_restart_addr;
    logic [3:0]  out_opcode;
    logic [11:0] out_offset;
    logic [9:0]  out_class;
    logic [15:0] out_mask, out_count, out_imm;
    logic        out_gather_insert, out_gather_type;
    logic [13:0] out_gather_words;
    logic        lock_acq, lock_rel, out_ext_unknown, out_bad_opcode;
    logic [7:0]  lock_idx;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cmd_hdr_decoder u_dut (.*);

    typedef struct packed {
        logic [31:0] w;
        logic        hdr;
        logic [11:0] ofs;
        logic [15:0] cnt;
        logic [3:0]  ev;   // {acq, rel, ext_unknown, bad}
    } vec_t;

    localparam vec_t VEC [26] = '{
        '{32'h1010_0003, 1'b1, 12'h010, 16'd3, 4'b0000}, // R2 incr hdr
        '{32'hAAAA_0001, 1'b0, 12'h010, 16'd0, 4'b0000}, // R2
        '{32'hAAAA_0002, 1'b0, 12'h011, 16'd0, 4'b0000}, // R2
        '{32'hAAAA_0003, 1'b0, 12'h012, 16'd0, 4'b0000}, // R2
        '{32'h2020_0002, 1'b1, 12'h020, 16'd2, 4'b0000}, // R3
        '{32'h5555_0001, 1'b0, 12'h020, 16'd0, 4'b0000}, // R3
        '{32'h5555_0002, 1'b0, 12'h020, 16'd0, 4'b0000}, // R3
        '{32'h3030_8005, 1'b1, 12'h030, 16'd3, 4'b0000}, // R4
        '{32'h0000_0001, 1'b0, 12'h030, 16'd0, 4'b0000}, // R4 bit 0
        '{32'h0000_0002, 1'b0, 12'h032, 16'd0, 4'b0000}, // R4 bit 2
        '{32'h0000_0003, 1'b0, 12'h03F, 16'd0, 4'b0000}, // R4 bit 15
        '{32'h0040_0AA4, 1'b1, 12'h040, 16'd2, 4'b0000}, // R5 mask 0x24
        '{32'h1111_1111, 1'b0, 12'h042, 16'd0, 4'b0000}, // R5
        '{32'h2222_2222, 1'b0, 12'h045, 16'd0, 4'b0000}, // R5
        '{32'h0040_0A80, 1'b1, 12'h040, 16'd0, 4'b0000}, // R5 zero mask
        '{32'h4050_1234, 1'b1, 12'h050, 16'd0, 4'b0000}, // R6 imm
        '{32'h5000_0010, 1'b1, 12'h000, 16'd0, 4'b0000}, // R6 restart
        '{32'h6060_C00A, 1'b1, 12'h060, 16'd1, 4'b0000}, // R7
        '{32'h8000_1000, 1'b0, 12'h060, 16'd0, 4'b0000}, // R7 address word
        '{32'hE000_0007, 1'b1, 12'h000, 16'd0, 4'b1000}, // R8 acquire
        '{32'hE100_0007, 1'b1, 12'h000, 16'd0, 4'b0100}, // R8 release
        '{32'hE500_0000, 1'b1, 12'h000, 16'd0, 4'b0010}, // R8 unknown
        '{32'h7000_0003, 1'b1, 12'h000, 16'd0, 4'b0001}, // R9
        '{32'h1070_0000, 1'b1, 12'h070, 16'd0, 4'b0000}, // R2 zero count; R9 next is hdr
        '{32'h1080_0001, 1'b1, 12'h080, 16'd1, 4'b0000}, // R1 header after zero count
        '{32'h0BAD_0BAD, 1'b0, 12'h080, 16'd0, 4'b0000}  // R2
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, settle, check, word is taken at the following posedge
    task automatic present(input logic [31:0] w, input logic rdy);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = w;
        out_ready = rdy;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; flush = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1 reset state
        chk(out_valid == 1'b0 && out_is_hdr == 1'b1, "R1 reset state", {30'b0, out_valid, out_is_hdr}, 32'h1);
        chk({lock_acq, lock_rel, out_ext_unknown, out_bad_opcode} == 4'b0, "R8 reset no pulse",
            {28'b0, lock_acq, lock_rel, out_ext_unknown, out_bad_opcode}, 32'h0);

        foreach (VEC[i]) begin
            present(VEC[i].w, 1'b1);
            chk(out_is_hdr == VEC[i].hdr, $sformatf("R1 tag vec %0d", i), {31'b0, out_is_hdr}, {31'b0, VEC[i].hdr});
            chk(out_offset == VEC[i].ofs, $sformatf("R2/R3/R4 offset vec %0d", i), {20'b0, out_offset}, {20'b0, VEC[i].ofs});
            if (VEC[i].hdr) begin
                chk(out_opcode == VEC[i].w[31:28], $sformatf("R1 opcode vec %0d", i), {28'b0, out_opcode}, {28'b0, VEC[i].w[31:28]});
                chk(out_count == VEC[i].cnt, $sformatf("R4/R5 count vec %0d", i), {16'b0, out_count}, {16'b0, VEC[i].cnt});
            end
            chk({lock_acq, lock_rel, out_ext_unknown, out_bad_opcode} == VEC[i].ev,
                $sformatf("R8/R9 events vec %0d", i),
                {28'b0, lock_acq, lock_rel, out_ext_unknown, out_bad_opcode}, {28'b0, VEC[i].ev});
            if (i == 11) chk(out_class == 10'h02A && out_mask == 16'h0024, "R5 class and mask",
                             {6'b0, out_class, out_mask}, {6'b0, 10'h02A, 16'h0024});
            if (i == 15) chk(out_imm == 16'h1234, "R6 immediate data", {16'b0, out_imm}, 32'h1234);
            if (i == 16) chk(out_restart_addr == 32'h0000_0100, "R6 restart address", out_restart_addr, 32'h100);
            if (i == 17) chk(out_gather_insert && out_gather_type && out_gather_words == 14'h00A, "R7 gather fields",
                             {16'b0, out_gather_insert, out_gather_type, out_gather_words}, 32'h0000_C00A);
            if (i == 19) chk(lock_idx == 8'h07, "R8 lock index", {24'b0, lock_idx}, 32'h7);
        end

        // R10 flush in the middle of a burst
        present(32'h1090_0005, 1'b1);
        present(32'hDEAD_0001, 1'b1);
        idle();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        present(32'h40A0_0042, 1'b1);
        chk(out_is_hdr == 1'b1 && out_opcode == 4'd4 && out_offset == 12'h0A0, "R10 header after flush",
            {19'b0, out_is_hdr, out_opcode, out_offset}, {19'b0, 1'b1, 4'd4, 12'h0A0});

        // R11 stalled downstream: ready follows, no pulse, state not advanced
        present(32'hE000_0033, 1'b0);
        chk(in_ready == 1'b0 && out_valid == 1'b1, "R11 handshake pass-through", {30'b0, in_ready, out_valid}, 32'h1);
        chk(lock_acq == 1'b0, "R11 no pulse while stalled", {31'b0, lock_acq}, 32'h0);
        present(32'hE000_0033, 1'b0);
        chk(out_is_hdr == 1'b1 && lock_acq == 1'b0, "R11 still header while stalled",
            {30'b0, out_is_hdr, lock_acq}, 32'h2);
        present(32'hE000_0033, 1'b1);
        chk(lock_acq == 1'b1 && lock_idx == 8'h33, "R8 pulse once accepted", {23'b0, lock_acq, lock_idx}, 32'h133);
        present(32'h20B0_0001, 1'b1);
        present(32'h1234_5678, 1'b0);
        present(32'h1234_5678, 1'b0);
        chk(out_is_hdr == 1'b0 && out_offset == 12'h0B0, "R11 payload held while stalled",
            {19'b0, out_is_hdr, 12'h0, out_offset}, {19'b0, 1'b0, 12'h0, 12'h0B0});
        present(32'h1234_5678, 1'b1);
        present(32'h40C0_0000, 1'b1);
        chk(out_is_hdr == 1'b1 && out_offset == 12'h0C0, "R3 run ends after count", {19'b0, out_is_hdr, 12'h0, out_offset},
            {19'b0, 1'b1, 12'h0, 12'h0C0});
        idle();

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule